// File: doc/BRIEF.md
# SPI Transaction FIFO and Event Unit

This block is the host side of an SPI master. Software fills a byte-wide transmit FIFO with 32-bit writes and issues one command that names a chip select and a frame length. The serial engine then pulls transmit bytes and returns received bytes through a narrow byte interface. A frame counter loaded by the command tells the engine when the frame starts and when it is over.

Received bytes collect in a second FIFO. Software drains it either a word at a time or, for the last one to three bytes, a byte at a time. An event register shows the live byte count of each FIFO next to two sticky flags: receive data present and transmit room available. The flags are cleared by writing ones, and a mask register routes them onto one interrupt line.

A mode register holds the global enable, internal loopback and two threshold fields. Four per-chip-select configuration words are stored, and the word for the active chip select is passed to the engine.

Top module: `spi_xfer_unit`

## Requirements
- R1: While reset is low, mode reads 0x0000_0403 (transmit threshold 4 in bits 13:8, receive threshold 3 in bits 5:0), and mask, command, event and irq_o read 0. busy_o is 0.
- R2: The registers sit at these byte offsets: mode 0x00 (writable bits 31, 30, 13:8, 5:0), event 0x04, mask 0x08 (bits 9 and 8 only), command 0x0C (bits 31:30 and 15:0 only), transmit data 0x10, receive data 0x14, and chip-select words 0x20/0x24/0x28/0x2C for chip selects 0 to 3. Reads of 0x18 and 0x1C return 0, and writes to them have no effect.
- R3: A word write to 0x10 pushes four bytes, bits 31:24 first, and the engine receives them in that order on tx_data_o. If fewer than four bytes are free, the whole word is dropped.
- R4: Event bits 29:24 show the receive FIFO byte count and bits 21:16 the transmit FIFO byte count. Both follow every push and pop. Each FIFO holds 32 bytes.
- R5: A word read of 0x14 pops up to four bytes, returning the oldest in bits 31:24 and zero below the bytes present. A read with byte_i high pops one byte and returns it in bits 7:0.
- R6: Event bit 9 (receive not empty) and bit 8 (transmit not full) are set whenever their condition holds. They stay set until a one is written to that bit, and they set again on the next cycle if the condition still holds.
- R7: irq_o is high exactly when some event flag at bit 9 or 8 is set and its mask bit is set.
- R8: A command write while enabled loads the frame counter with length+1 and pulses start_o for one cycle. busy_o stays high until that many bytes have arrived on rx_wr_i. cs_o shows command bits 31:30, and csmode_o shows that chip select's configuration word.
- R9: While mode bit 31 is low, both FIFOs are emptied and held empty, transmit writes are lost, and a command write neither sets busy_o nor pulses start_o.
- R10: en_o follows mode bit 31, and loop_o follows mode bit 30.
- R11: A byte arriving from the engine when the receive FIFO holds 32 bytes is dropped, and the bytes already stored are kept.
- R12: The largest length 0xFFFF keeps busy_o high for 65536 received bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | Single-byte read of the receive FIFO |
| addr_i | input | 6 | Byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| irq_o | output | 1 | Masked event interrupt |
| en_o | output | 1 | Controller enable |
| loop_o | output | 1 | Internal loopback select |
| start_o | output | 1 | One-cycle frame start pulse |
| busy_o | output | 1 | Frame bytes still outstanding |
| cs_o | output | 2 | Active chip select |
| csmode_o | output | 32 | Configuration word of the active chip select |
| tx_valid_o | output | 1 | Transmit byte available |
| tx_data_o | output | 8 | Oldest transmit byte |
| tx_rd_i | input | 1 | Engine takes one transmit byte |
| rx_wr_i | input | 1 | Engine delivers one received byte |
| rx_data_i | input | 8 | Received byte |

## Verification
The hardest states to reach are the boundaries of the FIFOs and the counter. These are a transmit word landing with fewer than four bytes free, a receive byte arriving at 32 bytes, and a frame of the full 65536 bytes. The bench gets to them by filling the FIFOs with repeated writes and pushes past capacity and by holding rx_wr_i high for the whole long frame. Sticky-flag clearing is tested only after the condition that set the flag has gone away, so that the clear can be seen at all.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] OFS_MODE = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_EVT  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 6'h14;
  localparam int B_EN   = 31;
  localparam int B_LOOP = 30;
  localparam int B_NE   = 9;
  localparam int B_NF   = 8;
  localparam logic [31:0] MODE_RST   = 32'h0000_0403;
  localparam logic [31:0] MODE_WMASK = 32'hC000_3F3F;
  typedef struct packed {
    logic ne;
    logic nf;
  } evt_t;
endpackage

// File: rtl/spi_xfer_fifo.sv
module spi_xfer_fifo #(
  parameter int DEPTH = 32,
  parameter int LANES = 4,
  localparam int CNT_W = $clog2(DEPTH) + 1,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int N_W   = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic [N_W-1:0]     push_n_i,
  input  logic [8*LANES-1:0] din_i,
  input  logic [N_W-1:0]     pop_n_i,
  output logic [8*LANES-1:0] dout_o,
  output logic [CNT_W-1:0]   count_o
);
  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q, free;
  logic [N_W-1:0]   push_eff, pop_eff;

  assign free     = CNT_W'(DEPTH) - cnt_q;
  // whole group dropped when it does not fit
  assign push_eff = (CNT_W'(push_n_i) <= free) ? push_n_i : '0;
  assign pop_eff  = (CNT_W'(pop_n_i) <= cnt_q) ? pop_n_i : N_W'(cnt_q);
  assign count_o  = cnt_q;

  always_ff @(posedge clk_i) begin
    if (!clr_i) begin
      for (int k = 0; k < LANES; k++) begin
        if (N_W'(k) < push_eff) mem[wp_q + PTR_W'(k)] <= din_i[8*(LANES-1-k) +: 8];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_q + PTR_W'(push_eff);
      rp_q  <= rp_q + PTR_W'(pop_eff);
      cnt_q <= cnt_q + CNT_W'(push_eff) - CNT_W'(pop_eff);
    end
  end

  for (genvar k = 0; k < LANES; k++) begin : g_peek
    assign dout_o[8*(LANES-1-k) +: 8] = (CNT_W'(k) < cnt_q) ? mem[rp_q + PTR_W'(k)] : 8'h00;
  end

  a_r11_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));
  a_r4_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_n_i == '0 && pop_n_i == '0 && !clr_i) |=> $stable(count_o));
endmodule

// File: rtl/spi_xfer_event.sv
module spi_xfer_event #(
  parameter int DEPTH = 32,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [CNT_W-1:0]          rx_cnt_i,
  input  logic [CNT_W-1:0]          tx_cnt_i,
  input  logic                      clr_we_i,
  input  spi_xfer_pkg::evt_t        clr_bits_i,
  input  spi_xfer_pkg::evt_t        mask_i,
  output spi_xfer_pkg::evt_t        flags_o,
  output logic                      irq_o
);
  spi_xfer_pkg::evt_t flg_q, cond, clr;

  assign cond.ne = rx_cnt_i != '0;
  assign cond.nf = tx_cnt_i != CNT_W'(DEPTH);
  assign clr     = clr_we_i ? clr_bits_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flg_q <= '0;
    else         flg_q <= (flg_q & ~clr) | cond;
  end

  assign flags_o = flg_q;
  assign irq_o   = |(flg_q & mask_i);

  a_r6_ne_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_bits_i.ne && rx_cnt_i == '0) |=> !flags_o.ne);
  a_r6_nf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt_i < CNT_W'(DEPTH)) |=> flags_o.nf);
endmodule

// File: rtl/spi_xfer_cmd.sv
module spi_xfer_cmd #(
  parameter int LEN_W = 16,
  parameter int CS_W  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             wr_i,
  input  logic [CS_W-1:0]  cs_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             tick_i,
  output logic [CS_W-1:0]  cs_o,
  output logic [LEN_W-1:0] len_o,
  output logic             start_o,
  output logic             busy_o
);
  localparam int C_W = LEN_W + 1;
  logic [C_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_o    <= '0;
      len_o   <= '0;
      cnt_q   <= '0;
      start_o <= 1'b0;
    end else begin
      if (wr_i) begin
        cs_o  <= cs_i;
        len_o <= len_i;
      end
      start_o <= en_i && wr_i;
      if (!en_i)                     cnt_q <= '0;
      else if (wr_i)                 cnt_q <= C_W'(len_i) + C_W'(1);
      else if (tick_i && busy_o)     cnt_q <= cnt_q - C_W'(1);
    end
  end

  assign busy_o = cnt_q != '0;

  a_r8_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> busy_o);
  a_r9_idle_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && $past(!en_i)) |-> !busy_o);
endmodule

// File: rtl/spi_xfer_unit.sv
module spi_xfer_unit #(
  parameter int FIFO_DEPTH = 32,
  parameter int LEN_W      = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic        byte_i,
  input  logic [5:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        en_o,
  output logic        loop_o,
  output logic        start_o,
  output logic        busy_o,
  output logic [1:0]  cs_o,
  output logic [31:0] csmode_o,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  input  logic        tx_rd_i,
  input  logic        rx_wr_i,
  input  logic [7:0]  rx_data_i
);
  import spi_xfer_pkg::*;
  localparam int CS_W  = 2;
  localparam int N_CS  = 1 << CS_W;
  localparam int LANES = 4;
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;
  localparam int N_W   = $clog2(LANES + 1);

  logic [31:0]      mode_q;
  evt_t             mask_q, flags;
  logic [31:0]      csm_q [N_CS];
  logic             wr, rd, csm_hit, clr;
  logic [CS_W-1:0]  csm_idx;
  logic [N_W-1:0]   tx_push, tx_pop, rx_push, rx_pop;
  logic [31:0]      tx_dout, rx_dout, rx_word;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [LEN_W-1:0] len_q;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign csm_hit = addr_i[5:4] == 2'b10 && addr_i[1:0] == 2'b00;
  assign csm_idx = addr_i[3:2];
  assign en_o    = mode_q[B_EN];
  assign loop_o  = mode_q[B_LOOP];
  assign clr     = !en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_RST;
      mask_q <= '0;
      for (int i = 0; i < N_CS; i++) csm_q[i] <= '0;
    end else if (wr) begin
      if (addr_i == OFS_MODE) mode_q <= wdata_i & MODE_WMASK;
      if (addr_i == OFS_MASK) mask_q <= '{ne: wdata_i[B_NE], nf: wdata_i[B_NF]};
      if (csm_hit)            csm_q[csm_idx] <= wdata_i;
    end
  end

  // FIFO traffic
  assign tx_push = (wr && addr_i == OFS_TXD) ? N_W'(LANES) : '0;
  assign tx_pop  = (tx_rd_i && tx_cnt != '0) ? N_W'(1) : '0;
  assign rx_push = rx_wr_i ? N_W'(1) : '0;
  always_comb begin
    rx_pop = '0;
    if (rd && addr_i == OFS_RXD) begin
      if (byte_i)                          rx_pop = (rx_cnt != '0) ? N_W'(1) : '0;
      else if (rx_cnt >= CNT_W'(LANES))    rx_pop = N_W'(LANES);
      else                                 rx_pop = N_W'(rx_cnt);
    end
  end

  spi_xfer_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) u_txf (
    .clk_i, .rst_ni, .clr_i(clr), .push_n_i(tx_push), .din_i(wdata_i),
    .pop_n_i(tx_pop), .dout_o(tx_dout), .count_o(tx_cnt));

  spi_xfer_fifo #(.DEPTH(FIFO_DEPTH), .LANES(LANES)) u_rxf (
    .clk_i, .rst_ni, .clr_i(clr), .push_n_i(rx_push), .din_i({rx_data_i, 24'h0}),
    .pop_n_i(rx_pop), .dout_o(rx_dout), .count_o(rx_cnt));

  assign tx_valid_o = tx_cnt != '0;
  assign tx_data_o  = tx_dout[31:24];
  assign rx_word    = byte_i ? {24'h0, rx_dout[31:24]} : rx_dout;

  spi_xfer_event #(.DEPTH(FIFO_DEPTH)) u_evt (
    .clk_i, .rst_ni, .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
    .clr_we_i(wr && addr_i == OFS_EVT),
    .clr_bits_i('{ne: wdata_i[B_NE], nf: wdata_i[B_NF]}),
    .mask_i(mask_q), .flags_o(flags), .irq_o(irq_o));

  spi_xfer_cmd #(.LEN_W(LEN_W), .CS_W(CS_W)) u_cmd (
    .clk_i, .rst_ni, .en_i(en_o), .wr_i(wr && addr_i == OFS_CMD),
    .cs_i(wdata_i[31:30]), .len_i(wdata_i[LEN_W-1:0]), .tick_i(rx_wr_i),
    .cs_o(cs_o), .len_o(len_q), .start_o(start_o), .busy_o(busy_o));

  assign csmode_o = csm_q[cs_o];

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        OFS_MODE: rdata_o = mode_q;
        OFS_EVT:  rdata_o = {2'b00, 6'(rx_cnt), 2'b00, 6'(tx_cnt), 6'h0, flags.ne, flags.nf, 8'h00};
        OFS_MASK: rdata_o = {22'h0, mask_q.ne, mask_q.nf, 8'h00};
        OFS_CMD:  rdata_o = {cs_o, 14'h0, 16'(len_q)};
        OFS_RXD:  rdata_o = rx_word;
        default:  rdata_o = csm_hit ? csm_q[csm_idx] : '0;
      endcase
    end
  end

  a_r3_word_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_TXD && en_o && !tx_rd_i && tx_cnt <= CNT_W'(FIFO_DEPTH - LANES))
      |=> tx_cnt == $past(tx_cnt) + CNT_W'(LANES));
  a_r7_irq_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));
  a_r10_mode_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == OFS_MODE) |=> (en_o == $past(wdata_i[B_EN])));
endmodule

// File: tb/spi_xfer_unit_test.sv
`timescale 1ns/1ps
module spi_xfer_unit_test;
  logic        clk = 1'b0, rst_n = 1'b1;
  logic        req = 0, we = 0, byte_rd = 0, tx_rd = 0, rx_wr = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0]  rx_data = '0, tx_data;
  logic        irq, en, loop, start, busy, tx_valid;
  logic [1:0]  cs;
  logic [31:0] csmode, v;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_xfer_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .byte_i(byte_rd),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .en_o(en),
    .loop_o(loop), .start_o(start), .busy_o(busy), .cs_o(cs), .csmode_o(csmode),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_rd_i(tx_rd), .rx_wr_i(rx_wr),
    .rx_data_i(rx_data));

  // addr, write data, expected readback
  localparam logic [95:0] VEC [0:8] = '{
    {32'h08, 32'hFFFF_FFFF, 32'h0000_0300},
    {32'h08, 32'h0000_0000, 32'h0000_0000},
    {32'h0C, 32'hC03F_0123, 32'hC000_0123},
    {32'h20, 32'h1111_2222, 32'h1111_2222},
    {32'h24, 32'h3333_4444, 32'h3333_4444},
    {32'h28, 32'h5555_6666, 32'h5555_6666},
    {32'h2C, 32'h7777_8888, 32'h7777_8888},
    {32'h18, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h00, 32'h0F0F_FFFF, 32'h0000_3F3F}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic b, output logic [31:0] d);
    @(negedge clk); req = 1; we = 0; addr = a; byte_rd = b;
    #1 d = rdata;
    @(negedge clk); req = 0; byte_rd = 0;
  endtask

  task automatic txpop;
    @(negedge clk); tx_rd = 1;
    @(negedge clk); tx_rd = 0;
  endtask

  task automatic rxpush(input logic [7:0] d);
    @(negedge clk); rx_wr = 1; rx_data = d;
    @(negedge clk); rx_wr = 0;
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    #1 rst_n = 0;
    // R1 reset values, read combinationally while reset is held
    req = 1; we = 0;
    addr = 6'h00; #1 chk("R1 mode", rdata, 32'h0000_0403);
    addr = 6'h08; #1 chk("R1 mask", rdata, 0);
    addr = 6'h0C; #1 chk("R1 cmd", rdata, 0);
    addr = 6'h04; #1 chk("R1 event", rdata, 0);
    req = 0;
    chk("R1 irq", {31'h0, irq}, 0);
    chk("R1 busy", {31'h0, busy}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 register map walk
    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][69:64], VEC[i][63:32]);
      rd(VEC[i][69:64], 1'b0, v);
      chk($sformatf("R2 vec%0d", i), v, VEC[i][31:0]);
    end
    rd(6'h1C, 1'b0, v); chk("R2 reserved 1C", v, 0);
    chk("R8 cs_o", {30'h0, cs}, 3);
    chk("R8 csmode_o", csmode, 32'h7777_8888);
    // R9 disabled: command did not start, tx write lost
    chk("R9 busy while off", {31'h0, busy}, 0);
    wr(6'h10, 32'hDEAD_BEEF);
    rd(6'h04, 1'b0, v); chk("R9 tx count while off", v, 32'h0000_0100);

    // R10 mode pins
    wr(6'h00, 32'hC000_0403);
    chk("R10 en", {31'h0, en}, 1);
    chk("R10 loop", {31'h0, loop}, 1);
    wr(6'h00, 32'h8000_0403);
    chk("R10 loop off", {31'h0, loop}, 0);

    // R3 byte order, R4 counts
    wr(6'h10, 32'hA1B2_C3D4);
    rd(6'h04, 1'b0, v); chk("R4 tx count 4", v, 32'h0004_0100);
    chk("R3 byte0", {24'h0, tx_data}, 32'hA1); txpop();
    chk("R3 byte1", {24'h0, tx_data}, 32'hB2); txpop();
    chk("R3 byte2", {24'h0, tx_data}, 32'hC3); txpop();
    chk("R3 byte3", {24'h0, tx_data}, 32'hD4); txpop();
    chk("R3 empty", {31'h0, tx_valid}, 0);

    // R3 full drop, R6 nf clear and re-set
    for (int i = 0; i < 9; i++) wr(6'h10, 32'h0102_0304 + i);
    rd(6'h04, 1'b0, v); chk("R3 drop at full", v, 32'h0020_0100);
    wr(6'h04, 32'h0000_0100);
    rd(6'h04, 1'b0, v); chk("R6 nf cleared", v, 32'h0020_0000);
    txpop();
    rd(6'h04, 1'b0, v); chk("R6 nf re-set", v, 32'h001F_0100);
    // R9 disable flushes
    wr(6'h00, 32'h0);
    rd(6'h04, 1'b0, v); chk("R9 flush", v[29:16], 0);
    wr(6'h00, 32'h8000_0403);

    // R8 frame of 6 bytes on cs 1
    wr(6'h0C, 32'h4000_0005);
    chk("R8 start", {31'h0, start}, 1);
    chk("R8 busy", {31'h0, busy}, 1);
    chk("R8 cs", {30'h0, cs}, 1);
    chk("R8 csmode", csmode, 32'h3333_4444);
    @(negedge clk); chk("R8 start one cycle", {31'h0, start}, 0);
    for (int i = 0; i < 5; i++) rxpush(8'h11 + 8'(i));
    chk("R8 busy after 5", {31'h0, busy}, 1);
    rxpush(8'h16);
    chk("R8 idle after 6", {31'h0, busy}, 0);
    rd(6'h04, 1'b0, v); chk("R4 rx count 6", v, 32'h0600_0300);

    // R7 interrupt masking
    chk("R7 no mask", {31'h0, irq}, 0);
    wr(6'h08, 32'h0000_0200); chk("R7 ne masked in", {31'h0, irq}, 1);
    wr(6'h08, 32'h0000_0100); chk("R7 nf masked in", {31'h0, irq}, 1);
    wr(6'h08, 32'h0); chk("R7 masked off", {31'h0, irq}, 0);

    // R5 word reads with tail padding
    rd(6'h14, 1'b0, v); chk("R5 word", v, 32'h1112_1314);
    rd(6'h14, 1'b0, v); chk("R5 tail word", v, 32'h1516_0000);
    rd(6'h04, 1'b0, v); chk("R6 ne sticky", v, 32'h0000_0300);
    wr(6'h04, 32'h0000_0200);
    rd(6'h04, 1'b0, v); chk("R6 ne cleared", v, 32'h0000_0100);

    // R5 byte reads
    rxpush(8'h21); rxpush(8'h22); rxpush(8'h23);
    rd(6'h14, 1'b1, v); chk("R5 byte read", v, 32'h21);
    rd(6'h04, 1'b0, v); chk("R4 rx count 2", v, 32'h0200_0300);

    // R11 receive overflow
    for (int i = 0; i < 33; i++) rxpush(8'h80 + 8'(i));
    rd(6'h04, 1'b0, v); chk("R11 rx full count", v, 32'h2000_0300);
    rd(6'h14, 1'b1, v); chk("R11 oldest kept", v, 32'h22);

    // R12 longest frame
    wr(6'h0C, 32'h0000_FFFF);
    chk("R12 busy start", {31'h0, busy}, 1);
    @(negedge clk); rx_wr = 1;
    repeat (65535) @(negedge clk);
    rx_wr = 0;
    chk("R12 busy at 65535", {31'h0, busy}, 1);
    rxpush(8'h00);
    chk("R12 idle at 65536", {31'h0, busy}, 0);

    finish_up();
  end
endmodule